// File: doc/BRIEF.md
# Table-Encoded SPI Clock Generator

This block derives the serial clock of an SPI master from the system clock. The divide ratio is not a free counter value. It is the product of two factors, each picked from a fixed table by a small code. A 2-bit code selects a non-power-of-two prescale factor. A 4-bit code selects a scale factor that grows from small even steps into powers of two. Both codes, the idle polarity and the capture phase are read from fixed bit positions of a 32-bit per-channel attribute word.

The transfer engine raises `run` to start clocking and lowers it to stop. While `run` is low, SCK rests at the polarity level and the block takes a fresh copy of the attribute fields. While `run` is high, a half-period counter toggles SCK. Each toggle also produces a one-cycle strobe that marks either a leading edge (away from idle) or a trailing edge (back to idle). Phase-resolved sample and shift strobes are derived from these so the shift register needs no phase logic of its own.

Top module: `spi_sck_gen`

## Requirements
- R1: Prescale code values 0, 1, 2 and 3 give prescale factors 2, 3, 5 and 7.
- R2: Scale code n gives factor 2, 4, 6 or 8 for n = 0 to 3, and 2^n for n = 4 to 15.
- R3: The prescale code is attribute bits 17:16 and the scale code is bits 3:0. Polarity is bit 26 and phase is bit 25. All other attribute bits have no effect.
- R4: While `run` stays high, SCK toggles every H system clocks, where H = prescale factor × scale factor / 2. The full SCK period is therefore the product of the two factors.
- R5: While `run` is low, `sck` equals the polarity bit, one clock after the attribute is presented.
- R6: The first SCK edge comes a full H clocks after `run` rises.
- R7: `lead_stb` is high for exactly the one clock in which SCK has just left its idle level. `trail_stb` is high for exactly the one clock in which SCK has just returned to it. The two strobes are never high together.
- R8: With phase 0, `sample_stb` follows `lead_stb` and `shift_stb` follows `trail_stb`. With phase 1, the two are swapped.
- R9: Divider codes, polarity and phase are taken only while `run` is low. A change during a run has no effect on that run.
- R10: With the largest codes (prescale 3, scale 15), H = 114688 and SCK still toggles at the right time.
- R11: One clock after `run` falls, `sck` is back at the idle level and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr | input | 32 | Per-channel attribute word holding the codes, polarity and phase |
| run | input | 1 | Clock enable from the transfer engine |
| sck | output | 1 | Serial clock |
| lead_stb | output | 1 | One-clock pulse at each leading SCK edge |
| trail_stb | output | 1 | One-clock pulse at each trailing SCK edge |
| sample_stb | output | 1 | Pulse at the edge where data is captured |
| shift_stb | output | 1 | Pulse at the edge where data is changed |

## Verification
The hardest situation to reach is a change of attribute codes while a run is already in progress. It looks harmless at the ports unless the edge timing is checked after it. The stimulus therefore rewrites the divider codes one clock into a run and keeps measuring every later edge against the half period computed from the old codes. The largest-code case is also hard to reach within a bounded run. It is exercised once, directed, by timing only its first edge, while random cases keep the scale code small so that many edges fit in the budget.

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int CNT_W    = 18,
  parameter int ATTR_W   = 32,
  parameter int PRE_LSB  = 16,
  parameter int SCL_LSB  = 0,
  parameter int CPOL_BIT = 26,
  parameter int CPHA_BIT = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ATTR_W-1:0] attr,
  input  logic              run,
  output logic              sck,
  output logic              lead_stb,
  output logic              trail_stb,
  output logic              sample_stb,
  output logic              shift_stb
);

  localparam int PRE_W = 2;
  localparam int SCL_W = 4;
  localparam int FAC_W = 3;

  function automatic logic [FAC_W-1:0] pre_factor(input logic [PRE_W-1:0] code);
    case (code)
      2'd0:    pre_factor = 3'd2;
      2'd1:    pre_factor = 3'd3;
      2'd2:    pre_factor = 3'd5;
      default: pre_factor = 3'd7;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] scl_half(input logic [SCL_W-1:0] code);
    if (code < 4'd4) scl_half = CNT_W'(code) + CNT_W'(1);
    else             scl_half = CNT_W'(1) << (code - 4'd1);
  endfunction

  logic [PRE_W-1:0] pre_code;
  logic [SCL_W-1:0] scl_code;
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] cnt;
  logic             cpol_q, cpha_q, tgl, hit;

  assign pre_code = attr[PRE_LSB +: PRE_W];
  assign scl_code = attr[SCL_LSB +: SCL_W];
  assign half_w   = CNT_W'(pre_factor(pre_code)) * scl_half(scl_code);
  assign hit      = (cnt == half_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= CNT_W'(1);
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      cnt       <= '0;
      tgl       <= 1'b0;
      sck       <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!run) begin
      half_q    <= half_w;
      cpol_q    <= attr[CPOL_BIT];
      cpha_q    <= attr[CPHA_BIT];
      cnt       <= '0;
      tgl       <= 1'b0;
      sck       <= attr[CPOL_BIT];
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= hit && !tgl;
      trail_stb <= hit && tgl;
      if (hit) begin
        cnt <= '0;
        tgl <= !tgl;
        sck <= !sck;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign sample_stb = cpha_q ? trail_stb : lead_stb;
  assign shift_stb  = cpha_q ? lead_stb  : trail_stb;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) run |-> cnt < half_q); // R10
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lead_stb && trail_stb)); // R7
  AST_EDGE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ((lead_stb || trail_stb) == (sck != $past(sck)))); // R7
  AST_LEAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) lead_stb |-> sck != cpol_q); // R7
  AST_TRAIL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) trail_stb |-> sck == cpol_q); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(half_q) && $stable(cpol_q) && $stable(cpha_q))); // R9
  AST_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0 && sck == cpol_q)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !(lead_stb || trail_stb)); // R11

endmodule

// File: tb/spi_sck_gen_test.sv
module spi_sck_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] attr = '0;
  logic        run = 1'b0;
  logic        sck, lead_stb, trail_stb, sample_stb, shift_stb;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  spi_sck_gen uut (
    .clk(clk), .rst_n(rst_n), .attr(attr), .run(run), .sck(sck),
    .lead_stb(lead_stb), .trail_stb(trail_stb),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  function automatic int exp_half(input int pre, input int scl);
    int pf, sf;
    case (pre)
      0: pf = 2;
      1: pf = 3;
      2: pf = 5;
      default: pf = 7;
    endcase
    if (scl < 4) sf = 2 * (scl + 1);
    else         sf = 1 << scl;
    return pf * sf / 2;
  endfunction

  function automatic logic [31:0] mk_attr(input int pre, input int scl, input bit cpol, input bit cpha);
    logic [31:0] a;
    a = $urandom;
    a[17:16] = pre[1:0];
    a[3:0]   = scl[3:0];
    a[26]    = cpol;
    a[25]    = cpha;
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int pre, input int scl, input bit cpol, input bit cpha,
                          input int nedges, input bit midchange, input string tag);
    int h;
    bit prev, changed, bad;
    h = exp_half(pre, scl);
    @(negedge clk);
    run  = 1'b0;
    attr = mk_attr(pre, scl, cpol, cpha);
    @(negedge clk);
    @(negedge clk);
    chk(sck == cpol && !lead_stb && !trail_stb, "R5 idle level", int'(sck), int'(cpol));
    run  = 1'b1;
    prev = sck;
    bad  = 1'b0;
    for (int e = 1; e <= nedges; e++) begin
      for (int k = 1; k <= h; k++) begin
        @(negedge clk);
        changed = (sck != prev);
        prev = sck;
        if (midchange && e == 1 && k == 1)
          attr = mk_attr((pre + 1) % 4, (scl + 3) % 6, cpol, !cpha);
        if (k < h) begin
          if (changed || lead_stb || trail_stb) bad = 1'b1;
        end else begin
          chk(changed, (e == 1) ? {tag, " R6 first edge after full half"} : {tag, " R4 edge spacing"},
              int'(changed), 1);
          chk(lead_stb == e[0] && trail_stb == !e[0], {tag, " R7 strobe kind"},
              int'({lead_stb, trail_stb}), e[0] ? 2 : 1);
          chk(sample_stb == (cpha ? trail_stb : lead_stb) && shift_stb == (cpha ? lead_stb : trail_stb),
              {tag, " R8 phase strobes"}, int'({sample_stb, shift_stb}), cpha ? int'({trail_stb, lead_stb}) : int'({lead_stb, trail_stb}));
          if (midchange) chk(changed, {tag, " R9 codes held during run"}, int'(changed), 1);
        end
      end
    end
    chk(!bad, {tag, " R4 no early edge or stray strobe"}, int'(bad), 0);
    run = 1'b0;
    @(negedge clk);
    chk(sck == cpol && !lead_stb && !trail_stb, {tag, " R11 stop to idle"}, int'({sck, lead_stb, trail_stb}), int'({cpol, 2'b00}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(sck == 1'b0 && !lead_stb && !trail_stb, "R5 reset state", int'({sck, lead_stb, trail_stb}), 0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) run_case(p, 0, p[0], p[1], 4, 1'b0, "R1 prescale");
    for (int s = 0; s < 10; s++) run_case(0, s, s[0], !s[0], 2, 1'b0, "R2 scale");
    run_case(2, 3, 1'b1, 1'b0, 3, 1'b0, "R3 field position noise");
    run_case(1, 2, 1'b0, 1'b1, 4, 1'b1, "R9 mid-run change");
    run_case(3, 4, 1'b1, 1'b1, 3, 1'b1, "R9 mid-run change 2");
    for (int i = 0; i < 24; i++)
      run_case($urandom % 4, $urandom % 6, 1'($urandom), 1'($urandom), 4, 1'($urandom), "R4 random");
    run_case(3, 15, 1'b0, 1'b0, 1, 1'b0, "R10 largest codes");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule